// File: doc/BRIEF.md
# Programmable Clock Divider with Half-Cycle Phase Delay

This block divides a fast distribution clock by a programmable integer and lets the phase of the divided output be placed anywhere on a half-cycle grid of that distribution clock. A synchronization pulse stops the divider and holds its output low. The output then restarts with its first rising edge after a programmed delay. That delay is a whole-cycle count, reduced by half a cycle when a half-step flag is set. The half-cycle position comes from a copy of the divided output retimed on the falling edge of the distribution clock. That copy is selected when the flag is set.

A small combinational calculator sits beside the divider. Given the divide value of a qualifying clock, it returns the delay count and half-step flag that put a freshly synchronized output at zero phase offset from that qualifying clock. Every sync applies the delay anew from its own edge. If the same output serves as the qualifying clock, each repeated sync with unchanged settings moves it by the same phase step again. Divide, delay and flag values are captured only at a sync edge, so software may rewrite them freely between sync events.

Top module: `hstep_clk_div`

## Requirements
- R1: After reset and until the first sync pulse, `clk_o` stays low and shows no rising edge.
- R2: A sync pulse sampled high on a rising clock edge forces `clk_o` low from that edge and restarts the divider. When the sync edge coincides with the edge where the running divider would start a new high phase, the sync wins and no rising edge appears there.
- R3: The first rising edge of `clk_o` after a sync edge comes P + 0.5*h distribution-clock cycles after that edge. Here h is the half-step flag and P = max(count - h, 1). For count >= 2 this equals count - 0.5*h cycles.
- R4: The half-step flag is sampled only at the sync edge. Changing it afterwards alters neither the delay already applied nor the following waveform.
- R5: While running with divide N, `clk_o` has a period of N cycles and a high phase of floor(N/2) cycles. An odd N therefore gives a high phase one cycle shorter than the low phase.
- R6: The divide value is clamped to the range 2 to 1045. A request of 1 acts as 2, and a request above 1045 acts as 1045.
- R7: Changes to the divide value or delay count between sync events leave the running output unchanged.
- R8: A second sync with the same settings restarts the output with the same delay measured from the new sync edge.
- R9: For qualifying divide q (clamped as in R6), let H = 2*ceil(16/q)*q + q - 23, in half cycles. The calculator returns count = ceil(H/2), with `zero_half_o` = 1 when H is odd. Examples: q=10 gives 14 with the flag set; q=20 gives 19 with the flag set; q=3 gives 8 with the flag clear.
- R10: The ceiling term leaves an exact quotient unchanged. q=16 gives 13 with the flag set, q=8 gives 9 with the flag set, and q=17 gives 14 with the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Distribution clock |
| rst_i | input | 1 | Synchronous active-high reset |
| div_i | input | 11 | Requested divide value |
| dly_cnt_i | input | 11 | Whole-cycle delay count |
| half_i | input | 1 | Half-step flag, subtracts half a cycle |
| sync_i | input | 1 | Synchronization pulse |
| qual_div_i | input | 11 | Divide value of the qualifying clock |
| clk_o | output | 1 | Divided, phase-delayed clock |
| zero_cnt_o | output | 11 | Delay count for zero offset |
| zero_half_o | output | 1 | Half-step flag for zero offset |

## Verification
The sync event and the divider's own wrap to a new high phase can land on the same distribution-clock edge. The bench first lets a divide-by-6 output rise. It then times the next sync pulse so that it is sampled exactly one output period later, on the edge where the divider would have raised `clk_o`. The result is judged by sampling `clk_o` just after that edge, where it must be low, and by measuring the next rising edge, which must come the full programmed delay after the sync edge.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
    localparam int DIV_W       = 11;
    localparam int DLY_W       = 11;
    localparam int DIV_MIN     = 2;
    localparam int DIV_MAX     = 1045;
    localparam int CEIL_NUM    = 16;
    localparam int BIAS_HALVES = 23;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } phase_st_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             half;
    } sync_cfg_t;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
        if (d < DIV_W'(DIV_MIN))      return DIV_W'(DIV_MIN);
        else if (d > DIV_W'(DIV_MAX)) return DIV_W'(DIV_MAX);
        else                          return d;
    endfunction

    // smallest k with k*q >= CEIL_NUM, q >= 2 assumed
    function automatic int ceil_quot(input int q);
        int k;
        k = CEIL_NUM;
        for (int i = CEIL_NUM; i >= 1; i--) begin
            if (i * q >= CEIL_NUM) k = i;
        end
        return k;
    endfunction

    function automatic int zero_halves(input int q);
        return 2 * ceil_quot(q) * q + q - BIAS_HALVES;
    endfunction
endpackage

// File: rtl/hsd_zero_calc.sv
module hsd_zero_calc
    import hsd_pkg::*;
#(
    parameter int QW = DIV_W,
    parameter int CW = DLY_W
) (
    input  logic [QW-1:0] qual_div_i,
    output logic [CW-1:0] zero_cnt_o,
    output logic          zero_half_o
);
    logic [DIV_W-1:0] q_c;
    int               halves;

    always_comb begin
        q_c         = clamp_div(DIV_W'(qual_div_i));
        halves      = zero_halves(int'(q_c));
        zero_cnt_o  = CW'((halves + 1) >>> 1);
        zero_half_o = halves[0];
    end

    // R9: 2*c*q is even, so the half flag follows the parity of q - 23
    always_comb begin
        assert_half_parity_R9: assert (zero_half_o == ~q_c[0]);
    end
endmodule

// File: rtl/hsd_phase_core.sv
module hsd_phase_core
    import hsd_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int LW = DLY_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          sync_i,
    input  logic [DW-1:0] div_i,
    input  logic [LW-1:0] dly_cnt_i,
    input  logic          half_i,
    output logic          pos_o,
    output logic          half_sel_o
);
    phase_st_e     st_q;
    sync_cfg_t     cfg_q;
    logic [LW-1:0] wait_q;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] cnt_nxt;
    logic [DW-1:0] hi_len;
    logic [LW-1:0] pos_cycles;

    always_comb begin
        if (dly_cnt_i <= LW'(half_i)) pos_cycles = LW'(1);
        else                          pos_cycles = dly_cnt_i - LW'(half_i);
        hi_len  = cfg_q.div >> 1;
        cnt_nxt = (cnt_q == cfg_q.div - DW'(1)) ? '0 : cnt_q + DW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= ST_IDLE;
            cfg_q  <= '{div: DW'(DIV_MIN), half: 1'b0};
            wait_q <= '0;
            cnt_q  <= '0;
            pos_o  <= 1'b0;
        end else if (sync_i) begin
            st_q   <= ST_WAIT;
            cfg_q  <= '{div: clamp_div(div_i), half: half_i};
            wait_q <= pos_cycles - LW'(1);
            cnt_q  <= '0;
            pos_o  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_WAIT: begin
                    if (wait_q == '0) begin
                        st_q  <= ST_RUN;
                        cnt_q <= '0;
                        pos_o <= 1'b1;
                    end else begin
                        wait_q <= wait_q - LW'(1);
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_nxt;
                    pos_o <= (cnt_nxt < hi_len);
                end
                default: pos_o <= 1'b0;
            endcase
        end
    end

    assign half_sel_o = cfg_q.half;

    assert_sync_holds_low_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_i |=> !pos_o);
    assert_cnt_in_range_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_RUN) |-> (cnt_q < cfg_q.div));
    assert_cfg_only_at_sync_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !sync_i |=> $stable(cfg_q));
    assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_IDLE) |-> !pos_o);
endmodule

// File: rtl/hsd_half_retime.sv
module hsd_half_retime (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pos_i,
    input  logic half_sel_i,
    output logic clk_o
);
    logic neg_q;

    always_ff @(negedge clk_i) begin
        if (rst_i) neg_q <= 1'b0;
        else       neg_q <= pos_i;
    end

    assign clk_o = half_sel_i ? neg_q : pos_i;

    // R4: the falling-edge copy trails the rising-edge path by half a cycle
    assert_retime_follows_R4: assert property (@(negedge clk_i) disable iff (rst_i)
        1'b1 |=> (neg_q == $past(pos_i)));
endmodule

// File: rtl/hstep_clk_div.sv
module hstep_clk_div
    import hsd_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int LW = DLY_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [DW-1:0] div_i,
    input  logic [LW-1:0] dly_cnt_i,
    input  logic          half_i,
    input  logic          sync_i,
    input  logic [DW-1:0] qual_div_i,
    output logic          clk_o,
    output logic [LW-1:0] zero_cnt_o,
    output logic          zero_half_o
);
    logic pos_w;
    logic half_sel_w;

    hsd_phase_core #(.DW(DW), .LW(LW)) core_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sync_i     (sync_i),
        .div_i      (div_i),
        .dly_cnt_i  (dly_cnt_i),
        .half_i     (half_i),
        .pos_o      (pos_w),
        .half_sel_o (half_sel_w)
    );

    hsd_half_retime retime_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .pos_i      (pos_w),
        .half_sel_i (half_sel_w),
        .clk_o      (clk_o)
    );

    hsd_zero_calc #(.QW(DW), .CW(LW)) calc_i (
        .qual_div_i  (qual_div_i),
        .zero_cnt_o  (zero_cnt_o),
        .zero_half_o (zero_half_o)
    );
endmodule

// File: tb/hstep_clk_div_tb_top.sv
`timescale 1ns/1ps
module hstep_clk_div_tb_top;
    localparam int TCK = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] div_i = 11'd10;
    logic [10:0] dly_i = 11'd4;
    logic        half_i = 1'b0;
    logic        sync_i = 1'b0;
    logic [10:0] qdiv_i = 11'd10;
    logic        clk_o;
    logic [10:0] zcnt;
    logic        zhalf;

    int n_cmp = 0;
    int n_bad = 0;
    int n_rise = 0;
    bit done = 0;

    hstep_clk_div dut_i (
        .clk_i(clk), .rst_i(rst), .div_i(div_i), .dly_cnt_i(dly_i),
        .half_i(half_i), .sync_i(sync_i), .qual_div_i(qdiv_i),
        .clk_o(clk_o), .zero_cnt_o(zcnt), .zero_half_o(zhalf)
    );

    always #(TCK/2) clk = ~clk;
    always @(posedge clk_o) n_rise++;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_sync(output realtime ts);
        @(negedge clk); sync_i = 1'b1;
        @(posedge clk); ts = $realtime;
        @(negedge clk); sync_i = 1'b0;
    endtask

    task automatic first_rise(input realtime ts, output realtime tr);
        #1; @(posedge clk_o); tr = $realtime;
    endtask

    task automatic shape(input realtime tr, output int hi, output int per);
        realtime tf, t2;
        @(negedge clk_o); tf = $realtime;
        @(posedge clk_o); t2 = $realtime;
        hi = int'(tf - tr); per = int'(t2 - tr);
    endtask

    task automatic run_case(input string tag, input int dv, input int dc, input bit h,
                            input int exp_halves, input int exp_per, input int exp_hi);
        realtime ts, tr; int hi, per;
        div_i = 11'(dv); dly_i = 11'(dc); half_i = h;
        do_sync(ts);
        first_rise(ts, tr);
        chk({tag, " R3 delay"}, int'(tr - ts), exp_halves * (TCK/2));
        shape(tr, hi, per);
        chk({tag, " R5 high"}, hi, exp_hi * TCK);
        chk({tag, " R5 period"}, per, exp_per * TCK);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 reset level", int'(clk_o), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk("R1 no edge before sync", n_rise, 0);
    endtask

    task automatic t_calc;
        int qs[7] = '{10, 20, 3, 16, 8, 17, 2};
        int cs[7] = '{14, 19, 8, 13, 9, 14, 6};
        int hs[7] = '{1, 1, 0, 1, 1, 0, 1};
        for (int i = 0; i < 7; i++) begin
            qdiv_i = 11'(qs[i]); #1;
            chk((i >= 3 && i <= 5) ? "R10 calc count" : "R9 calc count", int'(zcnt), cs[i]);
            chk((i >= 3 && i <= 5) ? "R10 calc half" : "R9 calc half", int'(zhalf), hs[i]);
        end
        qdiv_i = 11'd1045; #1;
        chk("R9 calc max count", int'(zcnt), 1556);
        chk("R9 calc max half", int'(zhalf), 0);
    endtask

    task automatic t_basic;
        run_case("div10 c14 h1", 10, 14, 1'b1, 27, 10, 5);
        run_case("div7 c5 h0", 7, 5, 1'b0, 10, 7, 3);
        run_case("div2 c3 h1", 2, 3, 1'b1, 5, 2, 1);
    endtask

    task automatic t_clamp;
        run_case("R3 clamp c1 h1", 4, 1, 1'b1, 3, 4, 2);
        run_case("R3 clamp c0 h0", 4, 0, 1'b0, 2, 4, 2);
        run_case("R6 div1", 1, 2, 1'b0, 4, 2, 1);
        run_case("R6 div2000", 2000, 2, 1'b0, 4, 1045, 522);
    endtask

    task automatic t_half_late;
        realtime ts, tr; int hi, per;
        div_i = 11'd4; dly_i = 11'd6; half_i = 1'b1;
        do_sync(ts);
        half_i = 1'b0;
        first_rise(ts, tr);
        chk("R4 late flag delay", int'(tr - ts), 44);
        shape(tr, hi, per);
        chk("R4 late flag period", per, 4 * TCK);
    endtask

    task automatic t_no_disturb;
        realtime ts, tr; int hi, per;
        div_i = 11'd6; dly_i = 11'd3; half_i = 1'b0;
        do_sync(ts);
        first_rise(ts, tr);
        div_i = 11'd9; dly_i = 11'd20;
        shape(tr, hi, per);
        chk("R7 period after div write", per, 6 * TCK);
        chk("R7 high after div write", hi, 3 * TCK);
    endtask

    task automatic t_repeat;
        realtime ts, tr;
        div_i = 11'd10; dly_i = 11'd14; half_i = 1'b1;
        do_sync(ts); first_rise(ts, tr);
        chk("R8 first sync delay", int'(tr - ts), 108);
        repeat (3) @(negedge clk);
        do_sync(ts); first_rise(ts, tr);
        chk("R8 repeated sync delay", int'(tr - ts), 108);
    endtask

    task automatic t_collide;
        realtime ts, tr, ts2;
        div_i = 11'd6; dly_i = 11'd4; half_i = 1'b0;
        do_sync(ts); first_rise(ts, tr);
        repeat (6) @(negedge clk);
        sync_i = 1'b1;
        @(posedge clk); ts2 = $realtime;
        #1;
        chk("R2 sync on wrap edge position", int'(ts2 - tr), 6 * TCK);
        chk("R2 sync wins over wrap", int'(clk_o), 0);
        @(negedge clk); sync_i = 1'b0;
        @(posedge clk_o); tr = $realtime;
        chk("R2 restart delay after collision", int'(tr - ts2), 4 * TCK);
    endtask

    initial begin
        t_reset;
        t_calc;
        t_basic;
        t_clamp;
        t_half_late;
        t_no_disturb;
        t_repeat;
        t_collide;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * TCK);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule